// File: doc/BRIEF.md
# Receive Ring Buffer Frame Writer

This block writes incoming Ethernet frames into a circular receive window of a local packet RAM built from 16-bit words. A byte stream carries start, end and error markers. Each frame is stored behind a four-word header: an event word, a status word, the address of the next frame and a byte count. The window is set in 256-byte pages by a lower and an upper page register. It runs from the first byte of the lower page to the last byte of the upper page. A host reads the RAM through its own read port, walks the chain of headers, and releases the space it has consumed by moving a 16-bit stop pointer.

A frame is made visible only by its event word. The writer streams the data first, then the status, next-pointer and count words, and then zeroes the event word of the following slot. It writes the event word of the frame itself last. If any word the frame needs would land on the word that holds the stop address, the frame is abandoned. It gets no header, the overrun counter steps by one, and the next frame reuses the same slot.

States: INIT (zero the first slot's event word) goes to IDLE. IDLE goes to RECV on a start byte, or to STAT on a one-byte frame. RECV goes to STAT on the end byte. STAT, NEXT, CNT and TERM step in that order. TERM goes to EVT, and EVT returns to IDLE. A blocked write sends RECV or IDLE to DROP when the frame has not yet ended, and to IDLE when it has. A blocked write in STAT, NEXT, CNT or TERM sends the writer to IDLE. DROP returns to IDLE on the end byte.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the stop register holds the upper page in its high byte and 0xFE in its low byte. The event word at the start of the lower page reads 0x0000.
- R2: A stored frame has its header at byte address H, with the event word at H, status at H+2, next-frame address at H+4 and byte count at H+6. Data starts at H+8 and holds two bytes per word, the earlier byte in bits 7:0.
- R3: The event word of a committed frame reads 0x0008.
- R4: The status word is 0x2000 when no byte of the frame carried the error flag. It is 0x0080 (bit 13 clear, an error bit of mask 0x0D81 set) when any byte did.
- R5: The count word holds the number of data bytes in bits 13:0, with bits 15:14 zero. An odd-length frame is padded with a zero byte in bits 15:8 of its last data word.
- R6: The next-frame address equals H+8 plus the padded length. Every address past the last byte of the upper page continues at the first byte of the lower page, for data as well as headers. The following frame is stored at the next-frame address.
- R7: The writer never writes the word that holds the stop address (the stop value with bit 0 cleared). A frame that needs that word is not committed, the overrun counter increases by one, and the next frame is stored at the same address.
- R8: Before committing a frame, the writer zeroes the event word at its next-frame address. The slot after the newest frame therefore never reads as done, even if an older frame was stored there.
- R9: Bytes that arrive outside a frame without the start flag are ignored. A start byte that arrives while a frame is being committed is ignored as well.
- R10: A stop value written by the host applies from the next clock cycle. Frames that the reset stop value would block are stored once the host has moved it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lower_page | input | 8 | First page of the receive window (byte address / 256) |
| upper_page | input | 8 | Last page of the receive window |
| stop_we | input | 1 | Host write strobe for the stop register |
| stop_din | input | 16 | New stop byte address |
| in_valid | input | 1 | A byte is present on in_data |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_err | input | 1 | Frame error flag, sampled with every byte |
| in_data | input | 8 | Received byte |
| host_rd_addr | input | ADDR_W-1 | Host read word address |
| host_rd_data | output | 16 | Word at host_rd_addr, one cycle later |
| ovf_count | output | OVF_W | Number of frames dropped at the stop pointer |

## Verification
The hardest case to reach from the ports is a frame that runs into the stop word part-way through. This is worse when the frame also wraps past the upper page, and worse again when a stale done event already sits in the slot that follows. The stimulus gets there by keeping the stop pointer at its reset value and sending equal frames until the window fills, so that later frames are dropped. The host then drains and moves the stop pointer, and frames of odd and even lengths wrap back over old slots. A reference ring model in the bench predicts each header address and each drop.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [3:0] {
        ST_INIT,
        ST_IDLE,
        ST_RECV,
        ST_DROP,
        ST_STAT,
        ST_NEXT,
        ST_CNT,
        ST_TERM,
        ST_EVT
    } wr_state_t;

    localparam logic [15:0] EVT_DONE  = 16'h0008;
    localparam logic [15:0] STAT_GOOD = 16'h2000;
    localparam logic [15:0] STAT_BAD  = 16'h0080;
    localparam int          LEN_W     = 14;

endpackage

// File: rtl/rxr_pktram.sv
module rxr_pktram #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [15:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [15:0]   rdata
);
    localparam int DEPTH = 1 << AW;

    logic [15:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/rxr_window.sv
module rxr_window #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        lower_page,
    input  logic [7:0]        upper_page,
    input  logic              stop_we,
    input  logic [15:0]       stop_din,
    output logic [ADDR_W-2:0] lo_w,
    output logic [ADDR_W-2:0] hi_w,
    output logic [ADDR_W-2:0] stop_w
);
    logic [15:0] stop_q;
    logic [15:0] lo_b, hi_b;
    logic        cfg_unused;

    assign lo_b   = {lower_page, 8'h00};
    assign hi_b   = {upper_page, 8'hFF};
    assign lo_w   = lo_b[ADDR_W-1:1];
    assign hi_w   = hi_b[ADDR_W-1:1];
    assign stop_w = stop_q[ADDR_W-1:1];
    assign cfg_unused = ^{lo_b[0], hi_b[0], stop_q[0],
                          lo_b[15:ADDR_W], hi_b[15:ADDR_W], stop_q[15:ADDR_W]};

    always_ff @(posedge clk) begin
        if (!rst_n)       stop_q <= {upper_page, 8'hFE};
        else if (stop_we) stop_q <= stop_din;
    end

    AST_STOP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        stop_we |=> stop_q == $past(stop_din)); // R10
    AST_WINDOW_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_b[15:ADDR_W] == '0) && (lo_b < hi_b)); // R6
endmodule

// File: rtl/rxr_writer.sv
module rxr_writer
    import rxr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OVF_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_err,
    input  logic [7:0]        in_data,
    input  logic [ADDR_W-2:0] lo_w,
    input  logic [ADDR_W-2:0] hi_w,
    input  logic [ADDR_W-2:0] stop_w,
    output logic              mem_we,
    output logic [ADDR_W-2:0] mem_waddr,
    output logic [15:0]       mem_wdata,
    output logic [OVF_W-1:0]  ovf_count
);
    localparam int AW = ADDR_W - 1;

    wr_state_t        state, nxt;
    logic [AW-1:0]    hdr, wp, fp, start_wp;
    logic [7:0]       lowb;
    logic             odd, err;
    logic [LEN_W-1:0] cnt;
    logic [OVF_W-1:0] ovf;
    logic             want, chk, hit;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic [2:0] n,
                                           input logic [AW-1:0] lo, input logic [AW-1:0] hi);
        logic [AW:0] s, span;
        s    = {1'b0, a} + {{(AW-2){1'b0}}, n};
        span = {1'b0, hi} - {1'b0, lo} + 1'b1;
        if (s > {1'b0, hi}) s = s - span;
        return s[AW-1:0];
    endfunction

    assign start_wp = step(hdr, 3'd4, lo_w, hi_w);

    // next state and write port
    always_comb begin
        nxt       = state;
        want      = 1'b0;
        chk       = 1'b1;
        mem_waddr = wp;
        mem_wdata = 16'h0000;
        unique case (state)
            ST_INIT: begin
                want = 1'b1; chk = 1'b0; mem_waddr = hdr; nxt = ST_IDLE;
            end
            ST_IDLE: if (in_valid && in_sof) begin
                if (in_eof) begin
                    want = 1'b1; mem_waddr = start_wp;
                    mem_wdata = {8'h00, in_data}; nxt = ST_STAT;
                end else begin
                    nxt = ST_RECV;
                end
            end
            ST_RECV: if (in_valid) begin
                if (odd || in_eof) begin
                    want = 1'b1;
                    mem_wdata = odd ? {in_data, lowb} : {8'h00, in_data};
                end
                if (in_eof) nxt = ST_STAT;
            end
            ST_DROP: if (in_valid && in_eof) nxt = ST_IDLE;
            ST_STAT: begin
                want = 1'b1; mem_waddr = fp;
                mem_wdata = err ? STAT_BAD : STAT_GOOD; nxt = ST_NEXT;
            end
            ST_NEXT: begin
                want = 1'b1; mem_waddr = fp;
                mem_wdata = 16'({wp, 1'b0}); nxt = ST_CNT;
            end
            ST_CNT: begin
                want = 1'b1; mem_waddr = fp;
                mem_wdata = {{(16-LEN_W){1'b0}}, cnt}; nxt = ST_TERM;
            end
            ST_TERM: begin
                want = 1'b1; nxt = ST_EVT;
            end
            ST_EVT: begin
                want = 1'b1; chk = 1'b0; mem_waddr = hdr;
                mem_wdata = EVT_DONE; nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
        hit = want && chk && (mem_waddr == stop_w);
        if (hit) nxt = ((state == ST_IDLE || state == ST_RECV) && !in_eof) ? ST_DROP : ST_IDLE;
        mem_we = want && !hit;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_INIT;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr <= lo_w; wp <= lo_w; fp <= lo_w;
            lowb <= '0; odd <= 1'b0; err <= 1'b0; cnt <= '0; ovf <= '0;
        end else begin
            if (hit) ovf <= ovf + 1'b1;
            unique case (state)
                ST_IDLE: if (in_valid && in_sof) begin
                    cnt  <= 1;
                    err  <= in_err;
                    fp   <= step(hdr, 3'd1, lo_w, hi_w);
                    lowb <= in_data;
                    odd  <= !in_eof;
                    wp   <= in_eof ? step(start_wp, 3'd1, lo_w, hi_w) : start_wp;
                end
                ST_RECV: if (in_valid) begin
                    cnt <= cnt + 1'b1;
                    err <= err | in_err;
                    if (odd || in_eof) begin
                        wp  <= step(wp, 3'd1, lo_w, hi_w);
                        odd <= 1'b0;
                    end else begin
                        lowb <= in_data;
                        odd  <= 1'b1;
                    end
                end
                ST_STAT, ST_NEXT, ST_CNT: fp <= step(fp, 3'd1, lo_w, hi_w);
                ST_EVT: hdr <= wp;
                default: ;
            endcase
        end
    end

    assign ovf_count = ovf;

    AST_EVT_AFTER_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_EVT |-> $past(state) == ST_TERM); // R8
    AST_OVR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf != $past(ovf) |-> ovf == $past(ovf) + 1'b1); // R7
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
    parameter int ADDR_W = 12,
    parameter int OVF_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        lower_page,
    input  logic [7:0]        upper_page,
    input  logic              stop_we,
    input  logic [15:0]       stop_din,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_err,
    input  logic [7:0]        in_data,
    input  logic [ADDR_W-2:0] host_rd_addr,
    output logic [15:0]       host_rd_data,
    output logic [OVF_W-1:0]  ovf_count
);
    localparam int AW = ADDR_W - 1;

    logic [AW-1:0] lo_w, hi_w, stop_w, mem_waddr;
    logic          mem_we;
    logic [15:0]   mem_wdata;

    rxr_window #(.ADDR_W(ADDR_W)) u_window (
        .clk(clk), .rst_n(rst_n), .lower_page(lower_page), .upper_page(upper_page),
        .stop_we(stop_we), .stop_din(stop_din),
        .lo_w(lo_w), .hi_w(hi_w), .stop_w(stop_w)
    );

    rxr_writer #(.ADDR_W(ADDR_W), .OVF_W(OVF_W)) u_writer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_err(in_err), .in_data(in_data),
        .lo_w(lo_w), .hi_w(hi_w), .stop_w(stop_w),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .ovf_count(ovf_count)
    );

    rxr_pktram #(.AW(AW)) u_ram (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(host_rd_addr), .rdata(host_rd_data)
    );

    AST_NO_STOP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_waddr != stop_w); // R7
    AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_waddr >= lo_w) && (mem_waddr <= hi_w)); // R6
endmodule

// File: tb/rx_ring_writer_test.sv
module rx_ring_writer_test;
    localparam int ADDR_W = 12;
    localparam int RB     = 32'h100;
    localparam int RE     = 32'h500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_we = 1'b0;
    logic [15:0] stop_din = '0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0;
    logic [7:0] in_data = '0;
    logic [ADDR_W-2:0] host_rd_addr = '0;
    logic [15:0] host_rd_data;
    logic [7:0]  ovf_count;

    always #5 clk = ~clk;

    rx_ring_writer #(.ADDR_W(ADDR_W), .OVF_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .lower_page(8'h01), .upper_page(8'h04),
        .stop_we(stop_we), .stop_din(stop_din),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err),
        .in_data(in_data), .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
        .ovf_count(ovf_count)
    );

    typedef struct {int hdr; int len; int err; int nxt; int seed;} exp_t;
    exp_t sb[$];
    int m_hdr = RB, m_stop = 32'h4FE, m_ovf = 0;
    int checks = 0, errors = 0;

    function automatic int wb(int a);
        return (a >= RE) ? a - (RE - RB) : a;
    endfunction

    function automatic logic [7:0] pat(int seed, int k);
        return 8'(seed * 7 + k * 13 + 1);
    endfunction

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // driver: predicts placement or drop, queues the expected frame, drives bytes
    task automatic send(int len, int err, int seed, bit glitch);
        exp_t e;
        int padded = (len + 1) & ~1;
        int a = m_hdr;
        bit drop = 1'b0;
        for (int k = 0; k < 3 + padded / 2 + 1; k++) begin
            a = wb(a + 2);
            if (a == (m_stop & ~1)) drop = 1'b1;
        end
        e.hdr = m_hdr; e.len = len; e.err = err; e.nxt = a; e.seed = seed;
        if (drop) m_ovf++;
        else begin sb.push_back(e); m_hdr = a; end
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (k == 0); in_eof = (k == len - 1);
            in_err = (err != 0) && (k == len / 2); in_data = pat(seed, k);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
        if (glitch) begin  // R9: start byte during commit
            in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_data = 8'hEE;
            @(negedge clk);
            in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic rd(int baddr, output int v);
        @(negedge clk);
        host_rd_addr = baddr[ADDR_W-1:1];
        @(negedge clk);
        v = host_rd_data;
    endtask

    task automatic set_stop(int v);
        @(negedge clk);
        stop_we = 1'b1; stop_din = v[15:0];
        @(negedge clk);
        stop_we = 1'b0;
        m_stop = v;
    endtask

    // monitor: pops expected frames and compares them with RAM contents
    task automatic drain();
        exp_t e;
        int v, car, exp_w, padded;
        while (sb.size() > 0) begin
            e = sb.pop_front();
            padded = (e.len + 1) & ~1;
            rd(e.hdr, v);     chk("R3 event", v, 16'h0008);
            rd(e.hdr + 2, v); chk("R4 status", v, e.err ? 16'h0080 : 16'h2000);
            rd(e.hdr + 4, v); chk("R6 next", v, e.nxt);
            rd(e.hdr + 6, v); chk("R5 count", v, e.len & 16'h3FFF);
            for (int w = 0; w < padded / 2; w++) begin
                exp_w = pat(e.seed, 2 * w);
                if (2 * w + 1 < e.len) exp_w = exp_w | (int'(pat(e.seed, 2 * w + 1)) << 8);
                rd(wb(e.hdr + 8 + 2 * w), v);
                chk((2 * w + 1 < e.len) ? "R2 data" : "R5 pad", v, exp_w);
            end
            car = wb(e.hdr + 8 + e.len);
            set_stop((car == RB) ? 32'h4FF : car - 1);  // R10
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        rd(RB, v);
        chk("R1 first slot event", v, 0);
        chk("R7 overrun at reset", ovf_count, 0);

        // fill against the reset stop value until frames are dropped
        for (int i = 0; i < 11; i++) send(100, 0, i + 1, 1'b0);
        chk("R1 R7 overrun count after fill", ovf_count, m_ovf);
        rd(m_hdr, v);
        chk("R7 dropped frame not committed", v, 0);
        drain();

        // wrapping frames, odd lengths, error flag, stray bytes, glitch start
        send(6, 0, 20, 1'b0);
        chk("R10 frame stored after stop moved", ovf_count, m_ovf);
        send(5, 0, 21, 1'b0);
        send(1, 1, 22, 1'b0);
        for (int k = 0; k < 3; k++) begin  // R9: bytes without start flag
            @(negedge clk);
            in_valid = 1'b1; in_data = 8'h5A;
        end
        @(negedge clk);
        in_valid = 1'b0;
        send(30, 1, 23, 1'b1);
        send(101, 0, 24, 1'b0);
        drain();
        rd(m_hdr, v);
        chk("R8 slot after newest frame", v, 0);
        chk("R9 overrun unchanged", ovf_count, m_ovf);

        // second lap over stale done events
        for (int i = 0; i < 6; i++) send(90 + i, i % 2, 30 + i, 1'b0);
        drain();
        rd(m_hdr, v);
        chk("R8 stale slot cleared", v, 0);
        chk("R7 overrun final", ovf_count, m_ovf);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule